// File: doc/BRIEF.md
# Status-Change Interrupt Aggregator

This block collects the condition signals of a line framer and turns them into one interrupt line. Two kinds of source are handled. A level source carries a condition that holds for a while, such as loss of frame alignment; the block samples it once per clock and records a change in either direction. An event source pulses for each occurrence, such as a checksum error or a multiframe boundary; the block records the pulse directly. Each source owns a sticky indication bit and an enable bit. The interrupt output is high when any indication with its enable set is pending.

Software reaches the block through a plain write port and a combinational read port. The address has two bank-select bits on top and a word index below. Bank 0 holds the sampled status levels (read only). Bank 1 holds the indications (write 1 to clear). Bank 2 holds the enables (read/write). Bank 3 is unmapped. Bit `b` of word `w` belongs to source `w*DATA_W + b`. Sources `0 .. N_LEVEL-1` are level sources and the rest are event sources.

Top module: `irq_status_agg`

## Requirements
- R1: An edge with `rst_n` low clears every indication, every enable and `irq_o`, and loads each level source's sample with its present input, so a level held steady across reset release sets no indication.
- R2: A read of bank 0 (address bits [ADDR_W-1:ADDR_W-2] = 0) returns, for each level source, its input as sampled at the last clock edge; event-source bits read 0.
- R3: For a level source, an input value that differs from the previous sample sets its indication at that edge, for both rising and falling changes.
- R4: For an event source, an input that is 1 at a clock edge sets its indication at that edge, whatever its previous value.
- R5: An indication stays 1 until a write to bank 1 with a 1 in its bit position clears it; a 0 in that position leaves it unchanged.
- R6: When a clear write and a new change or event for the same source fall at the same edge, the indication ends up 1.
- R7: A write to bank 2 loads the enable bits of the addressed word; enables read back from bank 2 and are 0 after reset.
- R8: `irq_o` is registered: one edge after any source has both indication and enable at 1 it is 1, and one edge after no such source exists it is 0.
- R9: Bank 3, word indices of `NW` or more, and bit positions past the last source read 0; writes to bank 0, bank 3 or such word indices change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all logic on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_in | input | N_SRC | Source conditions: levels for low indices, event pulses above |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write address: bank select on top, word index below |
| wr_data | input | DATA_W | Write data: clear mask for bank 1, enable values for bank 2 |
| rd_addr | input | ADDR_W | Read address, same layout as the write address |
| rd_data | output | DATA_W | Combinational read data for `rd_addr` |
| irq_o | output | 1 | Registered active-high interrupt |

## Verification
The bench targets a falling level edge, which a design detecting only rising edges would ignore, and a source held high through reset release, which a design whose sample register resets to 0 would flag as a false change. It lands a clear write on the same edge as a fresh event; a design giving the clear priority would lose the event. It masks a pending indication and re-enables it to catch an output that ignores the enables or is combinational rather than registered, and it writes to the read-only bank, to the unmapped bank and past the last word to catch decoders that alias those addresses onto real registers.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   typedef enum logic [1:0] {
      BANK_STAT = 2'd0,
      BANK_IND  = 2'd1,
      BANK_EN   = 2'd2,
      BANK_NONE = 2'd3
   } bank_e;

   function automatic int words_for(input int n_bits, input int word_w);
      return (n_bits + word_w - 1) / word_w;
   endfunction

   function automatic int index_width(input int n_words);
      return (n_words > 1) ? $clog2(n_words) : 1;
   endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell #(
   parameter bit IS_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_i,
   input  logic clr_i,
   input  logic en_we_i,
   input  logic en_d_i,
   output logic stat_o,
   output logic ind_o,
   output logic en_o
);

   logic set_w;
   logic ind_q;
   logic en_q;

   if (IS_LEVEL) begin : g_level
      logic samp_q;

      // During reset the sample follows the input, so the first edge after
      // release sees no difference unless the input actually moved.
      always_ff @(posedge clk) begin
         if (!rst_n) samp_q <= src_i;
         else        samp_q <= src_i;
      end

      assign set_w  = src_i ^ samp_q;
      assign stat_o = samp_q;

      // R3: any difference from the previous sample leaves the indication set
      a_r3_level_change: assert property (@(posedge clk) disable iff (!rst_n)
         (src_i != samp_q) |=> ind_q)
         else $error("R3 level change not recorded");
   end else begin : g_event
      assign set_w  = src_i;
      assign stat_o = 1'b0;

      // R4: a pulse sets the indication directly
      a_r4_event_direct: assert property (@(posedge clk) disable iff (!rst_n)
         src_i |=> ind_q)
         else $error("R4 event not recorded");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ind_q <= 1'b0;
         en_q  <= 1'b0;
      end else begin
         ind_q <= (ind_q & ~clr_i) | set_w;
         if (en_we_i) en_q <= en_d_i;
      end
   end

   assign ind_o = ind_q;
   assign en_o  = en_q;

   // R5: without a clear the indication never drops
   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ind_q && !clr_i) |=> ind_q)
      else $error("R5 indication dropped without clear");

   // R6: a set arriving with a clear wins
   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_w && clr_i) |=> ind_q)
      else $error("R6 clear beat a simultaneous set");

   // R7: enable loads on write and holds otherwise
   a_r7_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
      en_we_i |=> (en_q == $past(en_d_i)))
      else $error("R7 enable write lost");

   a_r7_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en_we_i |=> $stable(en_q))
      else $error("R7 enable changed without write");

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
   import irq_agg_pkg::*;
#(
   parameter int N_SRC  = 20,
   parameter int DATA_W = 8,
   parameter int NW     = 3,
   parameter int WIDX_W = 2,
   parameter int ADDR_W = 4
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [N_SRC-1:0]  stat_v,
   input  logic [N_SRC-1:0]  ind_v,
   input  logic [N_SRC-1:0]  en_v,
   output logic [N_SRC-1:0]  clr_v,
   output logic [N_SRC-1:0]  en_we_v,
   output logic [N_SRC-1:0]  en_d_v,
   output logic [DATA_W-1:0] rd_data
);

   localparam int PAD_W = NW * DATA_W;

   bank_e             wr_bank;
   bank_e             rd_bank;
   logic [WIDX_W-1:0] wr_idx;
   logic [WIDX_W-1:0] rd_idx;

   assign wr_bank = bank_e'(wr_addr[ADDR_W-1 -: 2]);
   assign rd_bank = bank_e'(rd_addr[ADDR_W-1 -: 2]);
   assign wr_idx  = wr_addr[WIDX_W-1:0];
   assign rd_idx  = rd_addr[WIDX_W-1:0];

   // Write decode, one slice per source
   for (genvar i = 0; i < N_SRC; i++) begin : g_wr
      localparam int WORD = i / DATA_W;
      localparam int BIT  = i % DATA_W;
      logic hit;
      assign hit        = wr_en && (wr_idx == WIDX_W'(WORD));
      assign clr_v[i]   = hit && (wr_bank == BANK_IND) && wr_data[BIT];
      assign en_we_v[i] = hit && (wr_bank == BANK_EN);
      assign en_d_v[i]  = wr_data[BIT];
   end

   // Read path: pad the source vectors to whole words, then select
   logic [PAD_W-1:0] stat_p;
   logic [PAD_W-1:0] ind_p;
   logic [PAD_W-1:0] en_p;

   always_comb begin
      stat_p = '0;
      ind_p  = '0;
      en_p   = '0;
      stat_p[N_SRC-1:0] = stat_v;
      ind_p[N_SRC-1:0]  = ind_v;
      en_p[N_SRC-1:0]   = en_v;
   end

   always_comb begin
      rd_data = '0;
      for (int w = 0; w < NW; w++) begin
         if (int'(rd_idx) == w) begin
            unique case (rd_bank)
               BANK_STAT: rd_data = stat_p[w*DATA_W +: DATA_W];
               BANK_IND:  rd_data = ind_p[w*DATA_W +: DATA_W];
               BANK_EN:   rd_data = en_p[w*DATA_W +: DATA_W];
               default:   rd_data = '0;
            endcase
         end
      end
   end

endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg #(
   parameter int N_SRC = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] ind_v,
   input  logic [N_SRC-1:0] en_v,
   output logic             irq_o
);

   logic irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(ind_v & en_v);
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
   import irq_agg_pkg::*;
#(
   parameter int  N_SRC   = 20,
   parameter int  N_LEVEL = 12,
   parameter int  DATA_W  = 8,
   localparam int NW      = words_for(N_SRC, DATA_W),
   localparam int WIDX_W  = index_width(NW),
   localparam int ADDR_W  = WIDX_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_o
);

   if (N_SRC < 1) begin : g_chk_src
      $error("N_SRC must be at least 1");
   end
   if (N_LEVEL < 0 || N_LEVEL > N_SRC) begin : g_chk_lvl
      $error("N_LEVEL must lie in 0..N_SRC");
   end
   if (DATA_W < 1) begin : g_chk_dw
      $error("DATA_W must be at least 1");
   end

   logic [N_SRC-1:0] stat_v;
   logic [N_SRC-1:0] ind_v;
   logic [N_SRC-1:0] en_v;
   logic [N_SRC-1:0] clr_v;
   logic [N_SRC-1:0] en_we_v;
   logic [N_SRC-1:0] en_d_v;

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      irq_src_cell #(
         .IS_LEVEL (i < N_LEVEL)
      ) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .src_i   (src_in[i]),
         .clr_i   (clr_v[i]),
         .en_we_i (en_we_v[i]),
         .en_d_i  (en_d_v[i]),
         .stat_o  (stat_v[i]),
         .ind_o   (ind_v[i]),
         .en_o    (en_v[i])
      );
   end

   irq_reg_port #(
      .N_SRC  (N_SRC),
      .DATA_W (DATA_W),
      .NW     (NW),
      .WIDX_W (WIDX_W),
      .ADDR_W (ADDR_W)
   ) u_port (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .stat_v  (stat_v),
      .ind_v   (ind_v),
      .en_v    (en_v),
      .clr_v   (clr_v),
      .en_we_v (en_we_v),
      .en_d_v  (en_d_v),
      .rd_data (rd_data)
   );

   irq_out_reg #(
      .N_SRC (N_SRC)
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .ind_v (ind_v),
      .en_v  (en_v),
      .irq_o (irq_o)
   );

   // R8: with every enable clear the output is low one edge later
   a_r8_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (en_v == '0) |=> !irq_o)
      else $error("R8 interrupt with all enables clear");

   // R8: with nothing pending the output is low one edge later
   a_r8_none_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (ind_v == '0) |=> !irq_o)
      else $error("R8 interrupt with no indication");

   // R5: clears only come from bank 1 writes
   a_r5_clear_source: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v != '0) |-> (wr_en && wr_addr[ADDR_W-1 -: 2] == 2'd1))
      else $error("R5 clear outside indication bank");

endmodule

// File: tb/sim_irq_status_agg.sv
module sim_irq_status_agg;

   localparam int N  = 20;
   localparam int NL = 12;
   localparam int DW = 8;
   localparam int NW = 3;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [N-1:0]  src_in;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] rd_data;
   logic          irq_o;

   always #10 clk = ~clk;

   irq_status_agg #(.N_SRC(N), .N_LEVEL(NL), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq_o(irq_o)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   // Behavioural reference model
   bit m_stat [N];
   bit m_ind  [N];
   bit m_en   [N];
   bit m_irq;

   always @(posedge clk) begin
      bit any;
      int bk;
      int wi;
      bit clr;
      bit set;
      any = 0;
      bk  = int'(wr_addr[3:2]);
      wi  = int'(wr_addr[1:0]);
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            m_stat[i] = (i < NL) ? src_in[i] : 1'b0;
            m_ind[i]  = 0;
            m_en[i]   = 0;
         end
         m_irq = 0;
      end else begin
         for (int i = 0; i < N; i++) any |= m_ind[i] & m_en[i];
         for (int i = 0; i < N; i++) begin
            set = (i < NL) ? (src_in[i] != m_stat[i]) : src_in[i];
            clr = wr_en && bk == 1 && wi == i / DW && wr_data[i % DW];
            m_ind[i] = (m_ind[i] && !clr) || set;
            if (wr_en && bk == 2 && wi == i / DW) m_en[i] = wr_data[i % DW];
            if (i < NL) m_stat[i] = src_in[i];
         end
         m_irq = any;
      end
   end

   function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
      logic [DW-1:0] v;
      int bk;
      int wi;
      v  = '0;
      bk = int'(a[3:2]);
      wi = int'(a[1:0]);
      if (wi < NW && bk != 3) begin
         for (int j = 0; j < DW; j++) begin
            if (wi * DW + j < N) begin
               case (bk)
                  0:       v[j] = m_stat[wi*DW + j];
                  1:       v[j] = m_ind[wi*DW + j];
                  default: v[j] = m_en[wi*DW + j];
               endcase
            end
         end
      end
      return v;
   endfunction

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // Advance one cycle and compare both outputs mid-cycle
   task automatic step(input string tag);
      logic [DW-1:0] e;
      @(posedge clk);
      #10;
      n_chk++;
      if (irq_o !== m_irq) begin
         n_fail++;
         $display("FAIL R8 (%s phase) irq_o got %b exp %b", tag, irq_o, m_irq);
      end
      e = exp_rd(rd_addr);
      n_chk++;
      if (rd_data !== e) begin
         n_fail++;
         $display("FAIL %s rd_data at %h got %h exp %h", tag, rd_addr, rd_data, e);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      step(tag);
      wr_en   = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_fail++;
         $display("FAIL watchdog expired (all requirements)");
         finish_run();
      end
   end

   initial begin
      rst_n   = 1'b0;
      src_in  = 20'h00A5F;
      wr_en   = 1'b0;
      wr_addr = '0;
      wr_data = '0;
      rd_addr = 4'h4;
      repeat (3) step("R1");
      rst_n = 1'b1;
      for (int w = 0; w < NW; w++) begin
         rd_addr = AW'(4 + w);
         step("R1");
      end
      for (int w = 0; w < NW; w++) begin
         rd_addr = AW'(8 + w);
         step("R1");
      end

      // enables
      for (int w = 0; w < NW; w++) begin
         rd_addr = AW'(8 + w);
         wr(AW'(8 + w), 8'hFF, "R7");
      end

      // falling level change on source 3
      rd_addr = 4'h4;
      src_in[3] = 1'b0;
      step("R3");
      step("R8");
      wr(4'h4, 8'h08, "R5");
      step("R5");
      // rising change
      src_in[3] = 1'b1;
      step("R3");
      wr(4'h4, 8'h00, "R5");
      step("R5");
      wr(4'h4, 8'hFF, "R5");
      step("R8");

      // event source 13
      rd_addr = 4'h5;
      src_in[13] = 1'b1;
      step("R4");
      src_in[13] = 1'b0;
      step("R4");
      wr(4'h5, 8'h20, "R5");
      step("R4");

      // clear and event on the same edge, source 14
      src_in[14] = 1'b1;
      wr(4'h5, 8'h40, "R6");
      src_in[14] = 1'b0;
      step("R6");
      wr(4'h5, 8'hFF, "R5");

      // masking, source 15
      src_in[15] = 1'b1;
      step("R4");
      src_in[15] = 1'b0;
      rd_addr = 4'h9;
      wr(4'h9, 8'h00, "R8");
      step("R8");
      step("R8");
      wr(4'h9, 8'h80, "R8");
      step("R8");
      step("R8");

      // status readback
      for (int w = 0; w < NW; w++) begin
         rd_addr = AW'(w);
         src_in  = 20'hC3A96 ^ (20'h11111 << w);
         step("R2");
         step("R2");
      end

      // unmapped and read-only addresses
      rd_addr = 4'hC;  step("R9");
      rd_addr = 4'h3;  step("R9");
      rd_addr = 4'h7;  step("R9");
      rd_addr = 4'h0;
      wr(4'h0, 8'h00, "R9");
      wr(4'hF, 8'hFF, "R9");
      rd_addr = 4'h8;
      wr(4'hB, 8'h00, "R9");
      rd_addr = 4'h6;
      wr(4'h7, 8'hFF, "R9");
      step("R9");

      // mixed traffic
      for (int k = 0; k < 1500; k++) begin
         src_in  = src_in ^ N'($urandom & $urandom);
         rd_addr = AW'($urandom);
         wr_en   = ($urandom % 3) == 0;
         wr_addr = AW'($urandom);
         wr_data = DW'($urandom);
         step("R3");
      end
      wr_en = 1'b0;
      rst_n = 1'b0;
      src_in = '1;
      rd_addr = 4'h4;
      step("R1");
      rst_n = 1'b1;
      step("R1");
      rd_addr = 4'h5;
      step("R1");
      finish_run();
   end

endmodule